// File: doc/BRIEF.md
# Neighbour Coincidence Array Trigger

This block decides, for a single telescope, whether its camera trigger should be kept at the array level. It takes time-stamped trigger messages from the telescope's own camera and from up to eight neighbouring telescopes. Together these nine form a sub-array. Every incoming stamp is shifted by a programmable signed offset for its port, which corrects for cable and propagation differences. Neighbour stamps are kept in a short per-port history.

A local trigger waits in a single pending slot until its coincidence window has closed on the block's free-running tick counter. At that point the block counts the enabled neighbours that have a corrected stamp inside the window. If enough of them agree, it emits a record. The record carries a telescope bitmap and the local reference stamp.

Local triggers that fail the coincidence test can still be sent on through a divide-by-M prescaler, and those records are flagged as bypass. A test-injection port can stand in for the live inputs for one cycle and fire any chosen set of ports with one stamp. This allows the trigger path to be exercised locally or from elsewhere in the array.

Top module: `nct_coinc_trigger`

## Requirements
- R1: During and right after reset, no record and no drop pulse are issued, and every live input ready is high.
- R2: The tick counter is 0 in the first cycle after reset and counts up by one each cycle. A pending local trigger with corrected stamp T is decided in the first cycle whose tick value t has signed(t - T) greater than the window W. Its record, if any, appears in the following cycle, and the pending slot is then free.
- R3: Each stamp is corrected by adding its port's 16-bit two's-complement offset, sign-extended to 32 bits. Port 0 is the local port and port k+1 is neighbour k. A neighbour counts when it holds a stored stamp S with signed(S - T) in the inclusive range [-W, +W]. Stamps stored in or after the decision cycle do not count.
- R4: A record is an accept when the number of counting neighbours is at least the threshold N. It is then issued with bypass clear, bitmap bit 0 set for the local telescope, bitmap bit k+1 set for each counting neighbour k, and stamp T.
- R5: A neighbour whose enable bit is clear never adds to the count and never appears in the bitmap.
- R6: With divider M non-zero, every M-th rejected local trigger produces a record with bypass set, carrying the same bitmap rule. With M = 0, rejected triggers produce nothing.
- R7: A local trigger that arrives while the pending slot is occupied (including its decision cycle) raises the drop pulse one cycle later. It does not change the pending trigger.
- R8: Each neighbour port keeps only its four newest stamps, and a fifth overwrites the oldest.
- R9: While injection is valid, live inputs are ignored and their ready is low. Injection-map bit p fires port p (bit 0 local, bit k+1 neighbour k) with the injection stamp.
- R10: Each record is a single-cycle valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid_i | input | 1 | Local camera trigger valid |
| loc_ts_i | input | 32 | Local trigger stamp in ticks |
| loc_ready_o | output | 1 | Local input ready (low during injection) |
| nbr_valid_i | input | 8 | Neighbour trigger valid, one per neighbour |
| nbr_ts_i | input | 256 | Neighbour stamps, neighbour k at bits 32k+31..32k |
| nbr_ready_o | output | 8 | Neighbour ready (low during injection) |
| inj_valid_i | input | 1 | Test injection valid |
| inj_map_i | input | 9 | Ports fired by the injection |
| inj_ts_i | input | 32 | Injected stamp |
| cfg_offset_i | input | 144 | Signed offset per port, port p at bits 16p+15..16p |
| cfg_win_i | input | 16 | Window half-width W in ticks |
| cfg_thresh_i | input | 4 | Neighbour count threshold N |
| cfg_div_i | input | 16 | Bypass divider M (0 disables) |
| cfg_mask_i | input | 8 | Neighbour enable bits |
| rec_valid_o | output | 1 | Record valid pulse |
| rec_map_o | output | 9 | Telescope bitmap of the record |
| rec_ts_o | output | 32 | Corrected local reference stamp |
| rec_bypass_o | output | 1 | Record produced by the prescaler |
| drop_o | output | 1 | Local trigger dropped because the slot was busy |

## Verification
A record is due exactly one cycle after the first cycle in which the tick counter is more than W ticks past the pending stamp. A drop pulse is due one cycle after the cycle in which the duplicate local trigger is presented. The bench advances its behavioural model at each rising edge, using the inputs and the model state from just before that edge, so both kinds of result fall in the same cycle as the design's registered outputs. Every output is then compared at the falling edge that follows. Each scenario also counts the records it received and compares that count with a value worked out by hand, so the model itself is cross-checked.

// File: rtl/nct_pkg.sv
package nct_pkg;
  localparam int TS_W  = 32;
  localparam int OFS_W = 16;

  typedef logic [TS_W-1:0] ts_t;

  // add a sign-extended port offset to a raw stamp
  function automatic ts_t ts_correct(ts_t raw, logic [OFS_W-1:0] off);
    return raw + {{(TS_W-OFS_W){off[OFS_W-1]}}, off};
  endfunction

  // stamp a lies within +/- w of reference r (wrap-safe)
  function automatic logic in_window(ts_t a, ts_t r, ts_t w);
    ts_t d;
    d = a - r;
    return ($signed(d) <= $signed(w)) && ($signed(d) >= -$signed(w));
  endfunction

  // window around reference r has fully elapsed at tick now
  function automatic logic window_done(ts_t now, ts_t r, ts_t w);
    ts_t d;
    d = now - r;
    return $signed(d) > $signed(w);
  endfunction
endpackage

// File: rtl/nct_nbr_buf.sv
module nct_nbr_buf
  import nct_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIN_W = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  ts_t              push_ts,
  input  ts_t              ref_ts,
  input  logic [WIN_W-1:0] win,
  output logic             hit
);
  ts_t              slot_q [DEPTH];
  logic [DEPTH-1:0] used_q;
  logic [PTR_W-1:0] wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      wr_q   <= '0;
    end else if (push) begin
      used_q[wr_q] <= 1'b1;
      wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= push_ts;
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (used_q[i] && in_window(slot_q[i], ref_ts, TS_W'(win))) hit = 1'b1;
    end
  end
endmodule

// File: rtl/nct_prescaler.sv
module nct_prescaler #(
  parameter int PS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reject,
  input  logic [PS_W-1:0] div,
  output logic            fire
);
  logic [PS_W-1:0] cnt_q;
  logic            armed;

  assign armed = reject && (div != '0);
  assign fire  = armed && (((PS_W+1)'(cnt_q) + 1'b1) >= {1'b0, div});

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (armed) cnt_q <= fire ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/nct_coinc_trigger.sv
module nct_coinc_trigger
  import nct_pkg::*;
#(
  parameter int NNBR  = 8,
  parameter int DEPTH = 4,
  parameter int WIN_W = 16,
  parameter int PS_W  = 16,
  localparam int NPORT = NNBR + 1,
  localparam int CNT_W = $clog2(NNBR + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   loc_valid_i,
  input  logic [TS_W-1:0]        loc_ts_i,
  output logic                   loc_ready_o,
  input  logic [NNBR-1:0]        nbr_valid_i,
  input  logic [NNBR*TS_W-1:0]   nbr_ts_i,
  output logic [NNBR-1:0]        nbr_ready_o,
  input  logic                   inj_valid_i,
  input  logic [NNBR:0]          inj_map_i,
  input  logic [TS_W-1:0]        inj_ts_i,
  input  logic [NPORT*OFS_W-1:0] cfg_offset_i,
  input  logic [WIN_W-1:0]       cfg_win_i,
  input  logic [CNT_W-1:0]       cfg_thresh_i,
  input  logic [PS_W-1:0]        cfg_div_i,
  input  logic [NNBR-1:0]        cfg_mask_i,
  output logic                   rec_valid_o,
  output logic [NNBR:0]          rec_map_o,
  output logic [TS_W-1:0]        rec_ts_o,
  output logic                   rec_bypass_o,
  output logic                   drop_o
);
  // named internal events, observed by the checker
  logic             loc_take;
  logic             loc_drop;
  logic             decide;
  logic             pass;
  logic             reject;
  logic             fire;
  logic             emit;
  logic             pend_q;
  ts_t              pend_ts_q;
  ts_t              now_q;

  logic [NPORT-1:0] eff_v;
  ts_t              eff_ts  [NPORT];
  ts_t              corr_ts [NPORT];
  logic [NNBR-1:0]  nbr_hit;
  logic [NNBR-1:0]  hit_m;
  logic [CNT_W-1:0] hit_cnt;

  assign loc_ready_o = !inj_valid_i;
  assign nbr_ready_o = {NNBR{!inj_valid_i}};

  // port intake: live stream or test injection, then offset correction
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic raw_v;
    ts_t  raw_ts;
    if (p == 0) begin : g_loc
      assign raw_v  = loc_valid_i;
      assign raw_ts = loc_ts_i;
    end else begin : g_nbr
      assign raw_v  = nbr_valid_i[p-1];
      assign raw_ts = nbr_ts_i[(p-1)*TS_W +: TS_W];
    end
    assign eff_v[p]   = inj_valid_i ? inj_map_i[p] : raw_v;
    assign eff_ts[p]  = inj_valid_i ? inj_ts_i : raw_ts;
    assign corr_ts[p] = ts_correct(eff_ts[p], cfg_offset_i[p*OFS_W +: OFS_W]);
  end

  // neighbour history buffers
  for (genvar k = 0; k < NNBR; k++) begin : g_buf
    nct_nbr_buf #(.DEPTH(DEPTH), .WIN_W(WIN_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (eff_v[k+1]),
      .push_ts (corr_ts[k+1]),
      .ref_ts  (pend_ts_q),
      .win     (cfg_win_i),
      .hit     (nbr_hit[k])
    );
  end

  assign hit_m = nbr_hit & cfg_mask_i;

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < NNBR; i++) hit_cnt = hit_cnt + CNT_W'(hit_m[i]);
  end

  assign loc_take = eff_v[0];
  assign loc_drop = loc_take && pend_q;
  assign decide   = pend_q && window_done(now_q, pend_ts_q, TS_W'(cfg_win_i));
  assign pass     = hit_cnt >= cfg_thresh_i;
  assign reject   = decide && !pass;
  assign emit     = decide && (pass || fire);

  nct_prescaler #(.PS_W(PS_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .reject (reject),
    .div    (cfg_div_i),
    .fire   (fire)
  );

  // tick counter and pending slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q     <= '0;
      pend_q    <= 1'b0;
      pend_ts_q <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (decide) pend_q <= 1'b0;
      if (loc_take && !pend_q) begin
        pend_q    <= 1'b1;
        pend_ts_q <= corr_ts[0];
      end
    end
  end

  // record output
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid_o  <= 1'b0;
      rec_map_o    <= '0;
      rec_ts_o     <= '0;
      rec_bypass_o <= 1'b0;
      drop_o       <= 1'b0;
    end else begin
      rec_valid_o <= emit;
      drop_o      <= loc_drop;
      if (emit) begin
        rec_map_o    <= {hit_m, 1'b1};
        rec_ts_o     <= pend_ts_q;
        rec_bypass_o <= !pass;
      end
    end
  end
endmodule

// File: rtl/nct_coinc_trigger_chk.sv
module nct_coinc_trigger_chk #(
  parameter int NNBR  = 8,
  parameter int PS_W  = 16,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rec_valid_o,
  input logic [NNBR:0]    rec_map_o,
  input logic             rec_bypass_o,
  input logic             drop_o,
  input logic [NNBR-1:0]  cfg_mask_i,
  input logic [CNT_W-1:0] cfg_thresh_i,
  input logic [PS_W-1:0]  cfg_div_i,
  input logic             pend_q,
  input logic             loc_take
);
  // R2
  slot_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> ($past(pend_q) && !pend_q));

  // R4
  accept_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && !rec_bypass_o) |->
      ($countones(rec_map_o[NNBR:1]) >= int'($past(cfg_thresh_i))));

  // R5
  masked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> ((rec_map_o[NNBR:1] & ~$past(cfg_mask_i)) == '0));

  // R6
  bypass_only_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && rec_bypass_o) |->
      (($countones(rec_map_o[NNBR:1]) < int'($past(cfg_thresh_i))) &&
       ($past(cfg_div_i) != '0)));

  // R7
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> ($past(pend_q) && $past(loc_take)));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |=> !rec_valid_o);
endmodule

bind nct_coinc_trigger nct_coinc_trigger_chk #(
  .NNBR(NNBR), .PS_W(PS_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rec_valid_o  (rec_valid_o),
  .rec_map_o    (rec_map_o),
  .rec_bypass_o (rec_bypass_o),
  .drop_o       (drop_o),
  .cfg_mask_i   (cfg_mask_i),
  .cfg_thresh_i (cfg_thresh_i),
  .cfg_div_i    (cfg_div_i),
  .pend_q       (pend_q),
  .loc_take     (loc_take)
);

// File: tb/nct_coinc_trigger_tb_top.sv
module nct_coinc_trigger_tb_top;
  localparam int NN = 8;
  localparam int HIST = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          loc_v = 1'b0;
  logic [31:0]   loc_ts = '0;
  logic          loc_rdy;
  logic [NN-1:0] nbr_v = '0;
  logic [31:0]   nts [NN];
  logic [NN*32-1:0] nbr_ts_flat;
  logic [NN-1:0] nbr_rdy;
  logic          inj_v = 1'b0;
  logic [NN:0]   inj_map = '0;
  logic [31:0]   inj_ts = '0;
  logic signed [15:0] offs [NN+1];
  logic [(NN+1)*16-1:0] off_flat;
  logic [15:0]   win = 16'd10;
  logic [3:0]    thr = 4'd1;
  logic [15:0]   div = '0;
  logic [NN-1:0] mask = '1;
  logic          rec_v;
  logic [NN:0]   rec_map;
  logic [31:0]   rec_ts;
  logic          rec_byp;
  logic          drop;

  always #4 clk = ~clk;  // 125 MHz

  always_comb begin
    for (int i = 0; i < NN; i++) nbr_ts_flat[i*32 +: 32] = nts[i];
    for (int i = 0; i <= NN; i++) off_flat[i*16 +: 16] = offs[i];
  end

  nct_coinc_trigger dut_i (
    .clk(clk), .rst_n(rst_n),
    .loc_valid_i(loc_v), .loc_ts_i(loc_ts), .loc_ready_o(loc_rdy),
    .nbr_valid_i(nbr_v), .nbr_ts_i(nbr_ts_flat), .nbr_ready_o(nbr_rdy),
    .inj_valid_i(inj_v), .inj_map_i(inj_map), .inj_ts_i(inj_ts),
    .cfg_offset_i(off_flat), .cfg_win_i(win), .cfg_thresh_i(thr),
    .cfg_div_i(div), .cfg_mask_i(mask),
    .rec_valid_o(rec_v), .rec_map_o(rec_map), .rec_ts_o(rec_ts),
    .rec_bypass_o(rec_byp), .drop_o(drop)
  );

  int    n_tests = 0;
  int    n_fail = 0;
  string phase_req = "R1";
  int    phase_recs = 0;

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_now;
  bit          m_pend;
  logic [31:0] m_tl;
  logic [31:0] nq [NN][$];
  int          m_pcnt;
  bit          e_rv, e_byp, e_drop;
  logic [NN:0] e_map;
  logic [31:0] e_ts;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_now = 0; m_pend = 0; m_tl = 0; m_pcnt = 0;
      e_rv = 0; e_byp = 0; e_drop = 0; e_map = '0; e_ts = '0;
      for (int i = 0; i < NN; i++) nq[i].delete();
    end else begin
      bit was_pend;
      bit lv;
      logic [31:0] lt;
      was_pend = m_pend;
      e_rv = 0; e_drop = 0;
      if (m_pend && (int'(m_now - m_tl) > int'(win))) begin
        int cnt;
        logic [NN:0] mp;
        cnt = 0; mp = '0; mp[0] = 1'b1;
        for (int k = 0; k < NN; k++) begin
          bit found;
          found = 0;
          foreach (nq[k][j]) begin
            int d;
            d = int'(nq[k][j] - m_tl);
            if (d >= -int'(win) && d <= int'(win)) found = 1;
          end
          if (found && mask[k]) begin cnt++; mp[k+1] = 1'b1; end
        end
        if (cnt >= int'(thr)) begin
          e_rv = 1; e_byp = 0; e_map = mp; e_ts = m_tl;
        end else if (div != 0) begin
          m_pcnt++;
          if (m_pcnt >= int'(div)) begin
            m_pcnt = 0; e_rv = 1; e_byp = 1; e_map = mp; e_ts = m_tl;
          end
        end
        m_pend = 0;
      end
      lv = inj_v ? inj_map[0] : loc_v;
      lt = inj_v ? inj_ts : loc_ts;
      if (lv) begin
        if (was_pend) e_drop = 1;
        else begin m_pend = 1; m_tl = lt + int'(offs[0]); end
      end
      for (int k = 0; k < NN; k++) begin
        bit v;
        v = inj_v ? inj_map[k+1] : nbr_v[k];
        if (v) begin
          nq[k].push_back((inj_v ? inj_ts : nts[k]) + int'(offs[k+1]));
          if (nq[k].size() > HIST) void'(nq[k].pop_front());
        end
      end
      m_now = m_now + 1;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (rec_v !== e_rv || (e_rv && (rec_map !== e_map || rec_ts !== e_ts ||
          rec_byp !== e_byp))) begin
        n_fail++;
        $display("FAIL %s record: valid=%0b map=%b ts=%0d byp=%0b expected valid=%0b map=%b ts=%0d byp=%0b",
                 phase_req, rec_v, rec_map, rec_ts, rec_byp, e_rv, e_map, e_ts, e_byp);
      end
      n_tests++;
      if (drop !== e_drop) begin
        n_fail++;
        $display("FAIL R7 drop (%s): got %0b expected %0b", phase_req, drop, e_drop);
      end
      if (rec_v) phase_recs++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic begin_phase(string r);
    @(negedge clk);
    phase_req = r;
    phase_recs = 0;
  endtask

  task automatic end_phase(int exp_recs);
    repeat (45) @(negedge clk);
    check(phase_recs == exp_recs, phase_req, phase_recs, exp_recs);
  endtask

  task automatic send_nbr(int k, logic [31:0] ts);
    @(negedge clk);
    nbr_v[k] = 1'b1; nts[k] = ts;
    @(negedge clk);
    nbr_v[k] = 1'b0;
  endtask

  task automatic send_loc(logic [31:0] ts);
    @(negedge clk);
    loc_v = 1'b1; loc_ts = ts;
    @(negedge clk);
    loc_v = 1'b0;
  endtask

  function automatic logic [31:0] base_ts();
    return m_now + 32'd20;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] b;
    for (int i = 0; i < NN; i++) nts[i] = '0;
    for (int i = 0; i <= NN; i++) offs[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rec_v == 0 && drop == 0, "R1", int'(rec_v) + int'(drop), 0);
    check(loc_rdy == 1 && nbr_rdy == '1, "R1", int'(nbr_rdy), 255);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rec_v == 0 && drop == 0, "R1", int'(rec_v), 0);

    // R4: two neighbours in window, threshold 2
    begin_phase("R4"); thr = 2; b = base_ts();
    send_nbr(0, b - 2); send_nbr(1, b + 5); send_loc(b);
    end_phase(1);

    // R3: window edges, +W counts, -W-1 does not
    begin_phase("R3"); thr = 1; b = base_ts();
    send_nbr(0, b + 10); send_nbr(1, b - 11); send_loc(b);
    end_phase(1);

    // R3: per-port offsets
    begin_phase("R3"); b = base_ts();
    offs[3] = -16'sd50; offs[0] = 16'sd5;
    send_nbr(2, b + 50); send_loc(b - 5);
    end_phase(1);
    offs[3] = '0; offs[0] = '0;

    // R3: neighbour arriving after the decision is not counted
    begin_phase("R3"); b = base_ts();
    send_loc(b);
    repeat (35) @(negedge clk);
    send_nbr(0, b);
    end_phase(0);

    // R5: masked neighbour excluded
    begin_phase("R5"); thr = 2; mask = 8'hFE; b = base_ts();
    send_nbr(0, b); send_nbr(1, b); send_loc(b);
    end_phase(0);
    begin_phase("R5"); thr = 1; b = base_ts();
    send_nbr(0, b); send_nbr(1, b + 1); send_loc(b);
    end_phase(1);
    mask = '1;

    // R6: divide by 3, six lone locals -> two bypass records
    begin_phase("R6"); div = 16'd3;
    for (int n = 0; n < 6; n++) begin
      send_loc(m_now);
      repeat (20) @(negedge clk);
    end
    end_phase(2);
    // R6: divider 0 passes nothing
    begin_phase("R6"); div = 16'd0;
    for (int n = 0; n < 3; n++) begin
      send_loc(m_now);
      repeat (20) @(negedge clk);
    end
    end_phase(0);

    // R7: second local while pending is dropped
    begin_phase("R7"); thr = 0; b = base_ts();
    @(negedge clk); loc_v = 1'b1; loc_ts = b;
    @(negedge clk); loc_ts = b + 1;
    @(negedge clk); loc_v = 1'b0;
    end_phase(1);
    thr = 1;

    // R8: five pushes evict the oldest in-window stamp
    begin_phase("R8"); b = base_ts();
    send_nbr(3, b);
    for (int n = 0; n < 4; n++) send_nbr(3, b + 32'd40000 + n);
    send_loc(b);
    end_phase(0);
    begin_phase("R8"); b = base_ts();
    send_nbr(4, b);
    for (int n = 0; n < 3; n++) send_nbr(4, b + 32'd40000 + n);
    send_loc(b);
    end_phase(1);

    // R9: injection replaces live inputs
    begin_phase("R9"); thr = 2; b = base_ts();
    @(negedge clk);
    inj_v = 1'b1; inj_map = 9'b000000111; inj_ts = b;
    nbr_v[5] = 1'b1; nts[5] = b;
    #1;
    check(loc_rdy == 0 && nbr_rdy == '0, "R9", int'(nbr_rdy), 0);
    @(negedge clk);
    inj_v = 1'b0; inj_map = '0; nbr_v[5] = 1'b0;
    end_phase(1);

    // R10 / R2: back-to-back locals after a decision
    begin_phase("R10"); thr = 0;
    for (int n = 0; n < 3; n++) send_loc(m_now - 32'd20);
    end_phase(3);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule